// File: doc/BRIEF.md
# Three-Mode Local Interrupt Timer

This block is the interrupt timer that sits beside each processor core. It has three ways of running. In one-shot countdown it counts down once from a loaded value. In periodic countdown it reloads that value every time it runs out. In absolute-deadline mode it fires when a free-running 64-bit timestamp, which enters as an input, reaches a stored target. When the timer expires and is not masked, it emits a single-cycle interrupt request together with an 8-bit vector. Interrupt delivery and arbitration downstream of that pulse are handled elsewhere.

Software reaches the timer through a small register port with a 2-bit address. Address 0 is the timer entry, which holds the vector, the mask and the mode bits. Address 1 is the 32-bit initial count. Address 2 is the read-only current count. Address 3 is the divide setting. The 64-bit deadline has its own write/read port. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is sampled.

A countdown advances only on timestamp ticks. A timestamp tick is any cycle whose `tsc` value differs from the value in the previous cycle. The divide setting slows the countdown by a power of two.

Top module: `core_irq_timer`

## Requirements
- R1: The timer entry (address 0) keeps only the bits in mask 0x000710FF. Its fields are: vector in [7:0], bit 12, mask in bit 16, periodic select in bit 17 and deadline-mode select in bit 18. Every other bit reads 0.
- R2: When parameter DEADLINE_EN is 0, every entry write forces bit 18 to 0.
- R3: While `sw_enable` is low, every entry write also sets the mask bit (16) to 1.
- R4: Any entry write that changes bit 18 disarms a running countdown or deadline, in either direction.
- R5: In countdown modes, writing the initial count (address 1) stops any countdown and loads the current count. A nonzero value starts counting down. The current count (address 2) reads initial minus elapsed divided ticks. The divide code is {bit3,bit1,bit0} of address 3. Codes 0 to 6 select divide-by 2, 4, 8, 16, 32, 64 and 128, and code 7 selects divide-by 1. A count of N at factor F expires N*F ticks after the write.
- R6: On a one-shot expiry, `irq_pulse` is high for exactly one cycle with `irq_vector` equal to entry[7:0]. The current count becomes 0 and the timer stops.
- R7: On a periodic expiry, the current count reloads from the initial count and counting continues, so pulses repeat every N*F ticks.
- R8: A set mask bit suppresses the pulse, but the expiry still takes effect: the count goes to 0 and the timer stops.
- R9: In deadline mode, writes to the initial count are ignored and the current count reads 0.
- R10: While deadline mode is off, deadline writes have no effect and `dl_rdata` reads 0.
- R11: In deadline mode, a deadline write disarms the old target and stores the new one, which reads back on `dl_rdata`. A value of 0 stays disarmed. A target at or below the timestamp fires on the next tick. Otherwise the timer fires on the tick where `tsc` reaches the target. Deadline expiry is one-shot.
- R12: Reset leaves the entry at 0x00010000 (masked), the initial count, current count and deadline at 0, the divide setting at 0xB (divide-by 1), the timer inactive and no pulse.
- R13: The countdown does not advance in cycles where `tsc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Controller software-enable; when low, entry writes force the mask |
| tsc | input | TS_W | Free-running timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 entry, 1 initial, 2 current, 3 divide |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dl_wr | input | 1 | Deadline write strobe |
| dl_wdata | input | TS_W | Deadline write data |
| dl_rdata | output | TS_W | Stored deadline, or 0 outside deadline mode |
| irq_pulse | output | 1 | Single-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with `irq_pulse` |

## Verification
The countdown is driven from a table that pairs initial counts with divide codes covering divide-by 1 and several powers of two up to 128. Each row runs in one-shot or periodic mode. The cycle distance to the pulse separates a wrong divide decode from an off-by-one in the load or expiry path, and a repeated pulse separates reload from stop. Deadlines are written above the running timestamp, below it and as 0, which exercises the three arming outcomes. A stalled timestamp, a masked expiry and mode flips in both directions show that the timer pauses, stays silent or disarms without a pulse.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

    localparam int REG_W = 32;
    localparam int VEC_W = 8;
    localparam int DIVC_W = 3;

    // register select codes
    localparam logic [1:0] A_ENTRY = 2'd0;
    localparam logic [1:0] A_INIT  = 2'd1;
    localparam logic [1:0] A_CUR   = 2'd2;
    localparam logic [1:0] A_DIV   = 2'd3;

    // entry field positions
    localparam int B_MASK     = 16;
    localparam int B_PERIODIC = 17;
    localparam int B_DLINE    = 18;

    localparam logic [REG_W-1:0] ENTRY_WMASK = 32'h0007_10FF;
    localparam logic [REG_W-1:0] ENTRY_RST   = 32'h0001_0000;
    localparam logic [REG_W-1:0] DIV_WMASK   = 32'h0000_000B;
    localparam logic [REG_W-1:0] DIV_RST     = 32'h0000_000B;

    function automatic logic [DIVC_W-1:0] div_code(input logic [REG_W-1:0] v);
        return {v[3], v[1:0]};
    endfunction

endpackage

// File: rtl/irqtmr_prescaler.sv
module irqtmr_prescaler #(
    parameter int PRESC_W = 7,
    parameter int CODE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              step
);
    localparam logic [CODE_W-1:0] CODE_BYPASS = '1;

    logic [PRESC_W-1:0] cnt_d, cnt_q;
    logic [PRESC_W-1:0] lim;

    always_comb begin
        if (code == CODE_BYPASS) lim = '0;
        else                     lim = PRESC_W'((32'd2 << code) - 32'd1);
        step  = en && tick && !clr && (cnt_q >= lim);
        cnt_d = cnt_q;
        if (clr)              cnt_d = '0;
        else if (en && tick)  cnt_d = step ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R13: without a timestamp tick the divider does not move
    p_hold_no_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/irqtmr_tsc_watch.sv
module irqtmr_tsc_watch #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] tsc,
    input  logic [TS_W-1:0] target,
    output logic            tick,
    output logic            due
);
    logic [TS_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = tsc;
        tick   = (tsc != prev_q);
        due    = (tsc >= target);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R13: a moved timestamp is always seen as a tick
    p_change_is_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tsc != $past(tsc)) |-> tick);

endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
    import irqtmr_pkg::*;
#(
    parameter bit DEADLINE_EN = 1'b1,
    parameter int TS_W        = 64,
    parameter int PRESC_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_enable,
    input  logic [TS_W-1:0]  tsc,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             dl_wr,
    input  logic [TS_W-1:0]  dl_wdata,
    output logic [TS_W-1:0]  dl_rdata,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);
    typedef struct packed {
        logic [REG_W-1:0] entry;
        logic [REG_W-1:0] init;
        logic [REG_W-1:0] cur;
        logic [REG_W-1:0] divcfg;
        logic [TS_W-1:0]  dline;
        logic             active;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    logic             tick, due, step;
    logic             presc_clr, presc_en, dl_mode, expire;
    logic [REG_W-1:0] ent_new;

    assign dl_mode   = st_q.entry[B_DLINE];
    assign presc_clr = reg_wr && (reg_addr == A_INIT) && !dl_mode;
    assign presc_en  = st_q.active && !dl_mode;

    irqtmr_tsc_watch #(.TS_W(TS_W)) i_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tsc    (tsc),
        .target (st_q.dline),
        .tick   (tick),
        .due    (due)
    );

    irqtmr_prescaler #(.PRESC_W(PRESC_W), .CODE_W(DIVC_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (presc_en),
        .clr   (presc_clr),
        .tick  (tick),
        .code  (div_code(st_q.divcfg)),
        .step  (step)
    );

    always_comb begin
        st_d    = st_q;
        expire  = 1'b0;
        ent_new = '0;

        // running timer
        if (st_q.active) begin
            if (dl_mode) begin
                expire = tick && due;
            end else if (step) begin
                if (st_q.cur <= REG_W'(1)) expire = 1'b1;
                else                       st_d.cur = st_q.cur - 1'b1;
            end
        end

        if (expire) begin
            st_d.vec = st_q.entry[VEC_W-1:0];
            if (!dl_mode && st_q.entry[B_PERIODIC]) begin
                st_d.cur = st_q.init;
            end else begin
                st_d.active = 1'b0;
                if (!dl_mode) st_d.cur = '0;
            end
        end
        st_d.irq = expire && !st_q.entry[B_MASK];

        // software writes take priority over the running update
        if (reg_wr) begin
            case (reg_addr)
                A_ENTRY: begin
                    ent_new = reg_wdata & ENTRY_WMASK;
                    if (!DEADLINE_EN) ent_new[B_DLINE] = 1'b0;
                    if (!sw_enable)   ent_new[B_MASK]  = 1'b1;
                    if (ent_new[B_DLINE] != st_q.entry[B_DLINE]) st_d.active = 1'b0;
                    st_d.entry = ent_new;
                end
                A_INIT: begin
                    if (!dl_mode) begin
                        st_d.init   = reg_wdata;
                        st_d.cur    = reg_wdata;
                        st_d.active = |reg_wdata;
                    end
                end
                A_DIV:   st_d.divcfg = reg_wdata & DIV_WMASK;
                default: ;
            endcase
        end

        if (dl_wr && dl_mode) begin
            st_d.dline  = dl_wdata;
            st_d.active = |dl_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.entry  <= ENTRY_RST;
            st_q.divcfg <= DIV_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_ENTRY: reg_rdata = st_q.entry;
            A_INIT:  reg_rdata = st_q.init;
            A_CUR:   reg_rdata = dl_mode ? '0 : st_q.cur;
            default: reg_rdata = st_q.divcfg;
        endcase
        dl_rdata   = dl_mode ? st_q.dline : '0;
        irq_pulse  = st_q.irq;
        irq_vector = st_q.vec;
    end

    // R6: one-shot countdown expiry ends at zero and inactive
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !dl_mode && !st_q.entry[B_PERIODIC] && !reg_wr && !dl_wr)
        |=> (!st_q.active && st_q.cur == '0));

    // R7: periodic expiry reloads and stays running
    p_periodic_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !dl_mode && st_q.entry[B_PERIODIC] && !reg_wr)
        |=> (st_q.active && st_q.cur == $past(st_q.init)));

    // R8: masked expiry gives no pulse
    p_masked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.entry[B_MASK]) |=> !irq_pulse);

    // R4: flipping deadline-mode disarms
    p_mode_flip_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENTRY && !dl_wr &&
         ((reg_wdata[B_DLINE] && DEADLINE_EN) != st_q.entry[B_DLINE]))
        |=> !st_q.active);

    // R9: initial count is frozen in deadline mode
    p_init_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_INIT && dl_mode) |=> st_q.init == $past(st_q.init));

    // R10: deadline write outside deadline mode is dropped
    p_dl_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_wr && !dl_mode) |=> st_q.dline == $past(st_q.dline));

endmodule

// File: tb/test_core_irq_timer.sv
module test_core_irq_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_enable = 1'b1;
    logic [63:0] ts = 64'd100;
    logic        ts_run = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata, rdata_nd;
    logic        dl_wr = 1'b0;
    logic [63:0] dl_wdata = '0;
    logic [63:0] dl_rdata, dl_rdata_nd;
    logic        irq, irq_nd;
    logic [7:0]  irq_vec, irq_vec_nd;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (ts_run) ts <= ts + 64'd1;

    core_irq_timer i_core_irq_timer (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .tsc(ts),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
        .dl_wr(dl_wr), .dl_wdata(dl_wdata), .dl_rdata(dl_rdata),
        .irq_pulse(irq), .irq_vector(irq_vec)
    );

    core_irq_timer #(.DEADLINE_EN(1'b0)) i_core_irq_timer_nodl (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .tsc(ts),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_nd),
        .dl_wr(dl_wr), .dl_wdata(dl_wdata), .dl_rdata(dl_rdata_nd),
        .irq_pulse(irq_nd), .irq_vector(irq_vec_nd)
    );

    typedef struct packed {
        logic [31:0] init;
        logic [2:0]  code;
        logic        per;
        logic [7:0]  vec;
    } row_t;

    localparam row_t TBL [6] = '{
        '{32'd5, 3'd7, 1'b0, 8'h31},
        '{32'd3, 3'd0, 1'b1, 8'h42},
        '{32'd4, 3'd1, 1'b0, 8'h55},
        '{32'd2, 3'd2, 1'b1, 8'hA7},
        '{32'd1, 3'd7, 1'b0, 8'h10},
        '{32'd2, 3'd6, 1'b0, 8'h99}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = rdata;
    endtask

    task automatic wr_dl_abs(input logic [63:0] v);
        @(negedge clk); #1;
        dl_wdata = v; dl_wr = 1'b1;
        @(negedge clk); #1;
        dl_wr = 1'b0;
    endtask

    task automatic wr_dl_rel(input longint off, output logic [63:0] v);
        @(negedge clk); #1;
        v = ts + 64'(off);
        dl_wdata = v; dl_wr = 1'b1;
        @(negedge clk); #1;
        dl_wr = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output bit hit, output int cnt, output logic [7:0] v);
        hit = 1'b0; cnt = 0; v = '0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            cnt = i + 1;
            if (irq) begin
                hit = 1'b1; v = irq_vec;
                break;
            end
        end
    endtask

    function automatic int factor(input logic [2:0] c);
        return (c == 3'd7) ? 1 : (2 << c);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] dlv;
        logic [7:0]  v;
        bit          hit;
        int          cnt;
        int          exp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R12 reset state
        rd_reg(2'd0, r); chk("R12 entry", r, 32'h0001_0000);
        rd_reg(2'd1, r); chk("R12 init", r, 0);
        rd_reg(2'd2, r); chk("R12 cur", r, 0);
        rd_reg(2'd3, r); chk("R12 div", r, 32'hB);
        chk("R12 irq", irq, 0);

        // R1 / R2 entry masking
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, r); chk("R1 entry mask", r, 32'h0007_10FF);
        chk("R2 no-deadline forces bit18", rdata_nd, 32'h0003_10FF);
        wr_reg(2'd0, 32'h0);

        // R3 software disable forces mask
        sw_enable = 1'b0;
        wr_reg(2'd0, 32'h20);
        rd_reg(2'd0, r); chk("R3 mask forced", r, 32'h0001_0020);
        sw_enable = 1'b1;
        wr_reg(2'd0, 32'h20);
        rd_reg(2'd0, r); chk("R3 mask free", r, 32'h20);

        // R5 R6 R7 table of countdown vectors
        foreach (TBL[k]) begin
            exp = int'(TBL[k].init) * factor(TBL[k].code);
            wr_reg(2'd3, {28'd0, TBL[k].code[2], 1'b0, TBL[k].code[1:0]});
            wr_reg(2'd0, {14'd0, TBL[k].per, 9'd0, TBL[k].vec});
            wr_reg(2'd1, TBL[k].init);
            wait_irq(exp + 20, hit, cnt, v);
            chk("R5 expiry distance", cnt, exp);
            chk("R6 vector", v, TBL[k].vec);
            if (TBL[k].per) begin
                wait_irq(exp + 20, hit, cnt, v);
                chk("R7 periodic repeat", cnt, exp);
                wr_reg(2'd1, 32'd0);
            end else begin
                #1; rd_reg(2'd2, r); chk("R6 cur zero", r, 0);
                wait_irq(exp + 10, hit, cnt, v);
                chk("R6 no second pulse", hit, 0);
            end
        end

        // R5 mid-count readback at divide-by 1
        wr_reg(2'd3, 32'hB);
        wr_reg(2'd1, 32'd10);
        repeat (3) @(negedge clk); #1;
        rd_reg(2'd2, r); chk("R5 partial count", r, 32'd7);
        wr_reg(2'd1, 32'd0);

        // R13 stalled timestamp
        ts_run = 1'b0;
        repeat (2) @(negedge clk); #1;
        wr_reg(2'd1, 32'd4);
        repeat (10) @(negedge clk); #1;
        rd_reg(2'd2, r); chk("R13 count holds", r, 32'd4);
        ts_run = 1'b1;
        wait_irq(30, hit, cnt, v);
        chk("R13 resumes", cnt, 5);

        // R8 masked expiry
        wr_reg(2'd0, 32'h0001_0066);
        wr_reg(2'd1, 32'd3);
        wait_irq(20, hit, cnt, v);
        chk("R8 no pulse", hit, 0);
        #1; rd_reg(2'd2, r); chk("R8 expiry took effect", r, 0);

        // R4 / R9 countdown then flip into deadline mode
        wr_reg(2'd0, 32'h0002_0021);
        wr_reg(2'd1, 32'd20);
        wr_reg(2'd0, 32'h0004_0021);
        rd_reg(2'd2, r); chk("R9 cur reads zero", r, 0);
        wr_reg(2'd1, 32'd5);
        rd_reg(2'd1, r); chk("R9 init ignored", r, 32'd20);
        wr_reg(2'd0, 32'h0000_0021);
        wait_irq(50, hit, cnt, v);
        chk("R4 disarm into deadline", hit, 0);

        // R10 deadline port outside deadline mode
        wr_dl_abs(64'd1234);
        chk("R10 read zero", dl_rdata, 0);
        wr_reg(2'd0, 32'h0004_0044);
        chk("R10 write dropped", dl_rdata, 0);

        // R11 future, past and zero deadlines
        wr_dl_rel(20, dlv);
        chk("R11 readback", dl_rdata, dlv);
        wait_irq(60, hit, cnt, v);
        chk("R11 future distance", cnt, 20);
        chk("R11 vector", v, 8'h44);
        wait_irq(40, hit, cnt, v);
        chk("R11 one-shot", hit, 0);
        wr_dl_rel(-5, dlv);
        wait_irq(20, hit, cnt, v);
        chk("R11 past fires next tick", cnt, 1);
        wr_dl_abs(64'd0);
        wait_irq(40, hit, cnt, v);
        chk("R11 zero stays disarmed", hit, 0);

        // R4 flip out of deadline mode disarms
        wr_dl_rel(30, dlv);
        wr_reg(2'd0, 32'h0000_0044);
        wr_reg(2'd0, 32'h0004_0044);
        wait_irq(60, hit, cnt, v);
        chk("R4 disarm out of deadline", hit, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule